// File: doc/BRIEF.md
# Programmable vertical blanking generator

This block produces the vertical component of a video blanking signal for an encoder that works in either 525-line or 625-line mode. A frame-wide line counter is cleared by an odd-field start strobe and advanced by a line strobe. Line zero is therefore the leading edge of the vertical sync that opens the odd field, not a broadcast line number.

Software programs a 9-bit start line and an 8-bit end line through byte-wide write strobes. Blanking asserts when the counter reaches the start line and negates when it reaches the end line. The even field uses the same two values plus a fixed offset: 262 lines in 525-line mode and 313 lines in 625-line mode. While blanking is asserted, the encoder must discard incoming pixel data. Both outputs are gated by an enable that indicates whether the blanking pin is configured as an output.

Top module: `vblank_gen`

## Requirements
- R1: After reset the start line is 0x103, the end line is 0x13, the line counter is 0, and `vblank` and `pix_ignore` are low.
- R2: A pulse on `wr_start_lo` loads `wr_data[7:0]` into start bits 7..0, and a pulse on `wr_start_hi` loads `wr_data[0]` into start bit 8. Each write leaves the other half unchanged. A written value is first used for matching on the cycle after the write.
- R3: A pulse on `wr_end` loads `wr_data[7:0]` as the end line, which is first used for matching on the cycle after the write.
- R4: The 10-bit line counter clears to 0 on `odd_start`, which takes priority over `line_stb`. Otherwise it increments on `line_stb`, and it holds at 1023 instead of wrapping.
- R5: Each time the counter is updated (by `odd_start` or `line_stb`), blanking asserts if the new count equals the start line and negates if the new count equals the end line. The result is visible on the cycle after the strobe.
- R6: When `std_625` is 0 (525-line mode), blanking also asserts at start+262 and negates at end+262.
- R7: When `std_625` is 1 (625-line mode), the even-field offset is 313 instead of 262.
- R8: If a new count matches both a start line and an end line, blanking asserts.
- R9: A counter update that matches neither value leaves the blanking state unchanged. Blanking also holds when no strobe occurs.
- R10: While `blank_out_en` is 0, `vblank` and `pix_ignore` are low. The blanking state keeps tracking the count, so raising the enable immediately shows the current state.
- R11: `pix_ignore` is high exactly when `vblank` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| odd_start | input | 1 | Odd-field start strobe; clears the line counter |
| line_stb | input | 1 | Line strobe; advances the line counter |
| std_625 | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| blank_out_en | input | 1 | Blanking pin configured as output |
| wr_start_lo | input | 1 | Write strobe for start line bits 7..0 |
| wr_start_hi | input | 1 | Write strobe for start line bit 8 |
| wr_end | input | 1 | Write strobe for end line |
| wr_data | input | 8 | Write data byte |
| vblank | output | 1 | Vertical blanking |
| pix_ignore | output | 1 | Discard pixel input |

## Verification
The hardest state to reach from the ports is the saturated line counter, because it is only visible through the absence of a second blanking event. The stimulus runs more than 1023 line strobes without a field start, using start and end values that would match again if the counter wrapped. The bench also places register writes on the same cycle as a line strobe, and a start line equal to the end line, to exercise the ordering rules. A behavioural model compares both outputs on every clock.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } vstd_e;
endpackage

// File: rtl/vbg_regs.sv
module vbg_regs #(
    parameter int                 START_W   = 9,
    parameter int                 END_W     = 8,
    parameter logic [START_W-1:0] START_RST = 9'h103,
    parameter logic [END_W-1:0]   END_RST   = 8'h13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_start_lo,
    input  logic                          wr_start_hi,
    input  logic                          wr_end,
    input  logic [vbg_pkg::BYTE_W-1:0]    wr_data,
    output logic [START_W-1:0]            start_line,
    output logic [END_W-1:0]              end_line
);
    localparam int LO_W = vbg_pkg::BYTE_W;
    localparam int HI_W = START_W - LO_W;

    typedef struct packed {
        logic [HI_W-1:0]  st_hi;
        logic [LO_W-1:0]  st_lo;
        logic [END_W-1:0] fin;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_data_bits;

    assign unused_data_bits = ^wr_data[LO_W-1:HI_W];

    always_comb begin
        r_d = r_q;
        if (wr_start_lo) r_d.st_lo = wr_data;
        if (wr_start_hi) r_d.st_hi = wr_data[HI_W-1:0];
        if (wr_end)      r_d.fin   = wr_data[END_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st_hi <= START_RST[START_W-1:LO_W];
            r_q.st_lo <= START_RST[LO_W-1:0];
            r_q.fin   <= END_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_line = {r_q.st_hi, r_q.st_lo};
    assign end_line   = r_q.fin;

    assert_start_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_hi |=> start_line[START_W-1:LO_W] == $past(wr_data[HI_W-1:0]));
    assert_start_lo_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start_hi && !wr_start_lo) |=> $stable(start_line[LO_W-1:0]));
    assert_end_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> end_line == $past(wr_data[END_W-1:0]));
endmodule

// File: rtl/vbg_line_ctr.sv
module vbg_line_ctr #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [LINE_W-1:0] count_next,
    output logic [LINE_W-1:0] count_q
);
    localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        logic [LINE_W-1:0] cnt;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr)
            c_d.cnt = '0;
        else if (adv && c_q.cnt != CNT_MAX)
            c_d.cnt = c_q.cnt + LINE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_next = c_d.cnt;
    assign count_q    = c_q.cnt;

    assert_ctr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count_q == '0);
    assert_ctr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && count_q != CNT_MAX) |=> count_q == $past(count_q) + LINE_W'(1));
    assert_ctr_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !clr) |=> count_q == CNT_MAX);
endmodule

// File: rtl/vbg_match.sv
module vbg_match #(
    parameter int LINE_W  = 10,
    parameter int VAL_W   = 9,
    parameter int OFF_525 = 262,
    parameter int OFF_625 = 313
) (
    input  logic [LINE_W-1:0] line,
    input  logic [VAL_W-1:0]  val,
    input  logic              std_625,
    output logic              hit
);
    localparam int NFIELD = 2;

    vbg_pkg::vstd_e    vstd;
    logic [LINE_W-1:0] even_off;
    logic [NFIELD-1:0] fhit;

    assign vstd     = vbg_pkg::vstd_e'(std_625);
    assign even_off = (vstd == vbg_pkg::STD_625) ? LINE_W'(OFF_625) : LINE_W'(OFF_525);

    for (genvar k = 0; k < NFIELD; k++) begin : g_field
        logic [LINE_W-1:0] cand;
        if (k == 0) begin : g_odd
            assign cand = LINE_W'(val);
        end else begin : g_even
            assign cand = LINE_W'(val) + even_off;
        end
        assign fhit[k] = (line == cand);
    end

    assign hit = |fhit;
endmodule

// File: rtl/vblank_gen.sv
module vblank_gen #(
    parameter int                 LINE_W    = 10,
    parameter int                 START_W   = 9,
    parameter int                 END_W     = 8,
    parameter int                 OFF_525   = 262,
    parameter int                 OFF_625   = 313,
    parameter logic [START_W-1:0] START_RST = 9'h103,
    parameter logic [END_W-1:0]   END_RST   = 8'h13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       odd_start,
    input  logic       line_stb,
    input  logic       std_625,
    input  logic       blank_out_en,
    input  logic       wr_start_lo,
    input  logic       wr_start_hi,
    input  logic       wr_end,
    input  logic [7:0] wr_data,
    output logic       vblank,
    output logic       pix_ignore
);
    typedef struct packed {
        logic blank;
    } blk_t;

    logic [START_W-1:0] start_line;
    logic [END_W-1:0]   end_line;
    logic [LINE_W-1:0]  cnt_next;
    logic [LINE_W-1:0]  cnt_q;
    logic               upd;
    logic               hit_start;
    logic               hit_end;
    blk_t               b_d, b_q;

    vbg_regs #(
        .START_W(START_W), .END_W(END_W),
        .START_RST(START_RST), .END_RST(END_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_start_lo(wr_start_lo), .wr_start_hi(wr_start_hi), .wr_end(wr_end),
        .wr_data(wr_data),
        .start_line(start_line), .end_line(end_line)
    );

    vbg_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .clr(odd_start), .adv(line_stb),
        .count_next(cnt_next), .count_q(cnt_q)
    );

    vbg_match #(.LINE_W(LINE_W), .VAL_W(START_W), .OFF_525(OFF_525), .OFF_625(OFF_625)) u_mstart (
        .line(cnt_next), .val(start_line), .std_625(std_625), .hit(hit_start)
    );

    vbg_match #(.LINE_W(LINE_W), .VAL_W(END_W), .OFF_525(OFF_525), .OFF_625(OFF_625)) u_mend (
        .line(cnt_next), .val(end_line), .std_625(std_625), .hit(hit_end)
    );

    assign upd = odd_start | line_stb;

    always_comb begin
        b_d = b_q;
        if (upd) begin
            if (hit_start)    b_d.blank = 1'b1;
            else if (hit_end) b_d.blank = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign vblank     = b_q.blank & blank_out_en;
    assign pix_ignore = b_q.blank & blank_out_en;

    assert_blank_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && hit_start) |=> b_q.blank);
    assert_blank_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && hit_end && !hit_start) |=> !b_q.blank);
    assert_blank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && (hit_start || hit_end)) |=> $stable(b_q.blank));
    assert_count_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd) |=> $stable(cnt_q));
endmodule

// File: tb/sim_vblank_gen.sv
`timescale 1ns/1ps
module sim_vblank_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       odd_start = 1'b0, line_stb = 1'b0, std_625 = 1'b0, blank_out_en = 1'b1;
    logic       wr_start_lo = 1'b0, wr_start_hi = 1'b0, wr_end = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       vblank, pix_ignore;

    int    checks = 0, errors = 0;
    bit    finished = 0;
    string tag = "R1";

    int m_cnt = 0, m_start = 'h103, m_end = 'h13;
    bit m_blank = 0;

    always #2 clk = ~clk;

    vblank_gen u0 (
        .clk(clk), .rst_n(rst_n), .odd_start(odd_start), .line_stb(line_stb),
        .std_625(std_625), .blank_out_en(blank_out_en),
        .wr_start_lo(wr_start_lo), .wr_start_hi(wr_start_hi), .wr_end(wr_end),
        .wr_data(wr_data), .vblank(vblank), .pix_ignore(pix_ignore)
    );

    // Behavioural reference: count first, match with held values, then apply writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_start = 'h103; m_end = 'h13; m_blank = 0;
        end else begin
            int off;
            off = std_625 ? 313 : 262;
            if (odd_start || line_stb) begin
                if (odd_start) m_cnt = 0;
                else if (m_cnt < 1023) m_cnt = m_cnt + 1;
                if (m_cnt == m_start || m_cnt == m_start + off) m_blank = 1;
                else if (m_cnt == m_end || m_cnt == m_end + off) m_blank = 0;
            end
            if (wr_start_lo) m_start = (m_start & 'h100) | wr_data;
            if (wr_start_hi) m_start = (m_start & 'h0FF) | (int'(wr_data[0]) << 8);
            if (wr_end) m_end = wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit e;
        e = m_blank & blank_out_en;
        check(vblank === e, tag, vblank, e);
        check(pix_ignore === vblank, "R11", pix_ignore, vblank);
    endtask

    task automatic cyc(input bit os, input bit ls, input bit wl, input bit wh,
                       input bit we, input logic [7:0] d);
        odd_start = os; line_stb = ls; wr_start_lo = wl; wr_start_hi = wh;
        wr_end = we; wr_data = d;
        @(posedge clk); #1;
        odd_start = 0; line_stb = 0; wr_start_lo = 0; wr_start_hi = 0; wr_end = 0;
        compare();
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        check(vblank === 1'b0, "R1", vblank, 0);
        check(pix_ignore === 1'b0, "R1", pix_ignore, 0);
        tag = "R1"; cyc(1, 0, 0, 0, 0, 8'h00);
        run_lines(259);
        check(vblank === 1'b1, "R1 default start 0x103", vblank, 1);
        tag = "R5"; run_lines(20);
        tag = "R6"; run_lines(245);
        tag = "R9"; cyc(0, 0, 0, 0, 0, 8'h00); cyc(0, 0, 0, 0, 0, 8'h00);
        tag = "R5"; cyc(1, 0, 0, 0, 0, 8'h00); run_lines(30);
        check(vblank === 1'b0, "R5 negate at end line", vblank, 0);

        // R7: 625-line mode with new values
        std_625 = 1; tag = "R7";
        cyc(0, 0, 1, 0, 0, 8'h20); cyc(0, 0, 0, 1, 0, 8'h00); cyc(0, 0, 0, 0, 1, 8'h05);
        cyc(1, 0, 0, 0, 0, 8'h00); run_lines(624); cyc(1, 0, 0, 0, 0, 8'h00); run_lines(10);

        // R2: high half alone
        tag = "R2"; cyc(0, 0, 0, 1, 0, 8'hFF);
        cyc(1, 0, 0, 0, 0, 8'h00); run_lines(400);
        // R2: write on same cycle as a matching strobe uses the held value
        cyc(1, 0, 0, 0, 0, 8'h00);
        cyc(0, 1, 1, 1, 0, 8'h01); run_lines(300);

        // R3: end only
        tag = "R3"; cyc(0, 0, 0, 0, 1, 8'h40);
        cyc(1, 0, 0, 0, 0, 8'h00); run_lines(330);

        // R8: start equals end
        tag = "R8"; std_625 = 0;
        cyc(0, 0, 1, 0, 0, 8'h0A); cyc(0, 0, 0, 1, 0, 8'h00); cyc(0, 0, 0, 0, 1, 8'h0A);
        cyc(1, 0, 0, 0, 0, 8'h00); run_lines(10);
        check(vblank === 1'b1, "R8 assert wins", vblank, 1);
        run_lines(270);

        // R10: enable low, tracking continues
        tag = "R10"; cyc(0, 0, 0, 0, 1, 8'h30);
        cyc(1, 0, 0, 0, 0, 8'h00);
        blank_out_en = 0; run_lines(20);
        check(vblank === 1'b0 && pix_ignore === 1'b0, "R10 gated", vblank, 0);
        blank_out_en = 1; #0 compare();
        check(vblank === 1'b1, "R10 state kept", vblank, 1);
        run_lines(100);

        // R4: saturation and clear priority
        tag = "R4";
        cyc(0, 0, 1, 0, 0, 8'h05); cyc(0, 0, 0, 0, 1, 8'h06);
        cyc(1, 0, 0, 0, 0, 8'h00); run_lines(1100);
        check(vblank === 1'b0, "R4 no wrap", vblank, 0);
        cyc(1, 1, 0, 0, 0, 8'h00); run_lines(5);
        check(vblank === 1'b1, "R4 clear priority", vblank, 1);
        run_lines(3);

        finish_run();
    end
endmodule